// File: doc/BRIEF.md
# Three-wire serial EEPROM shift engine

This block runs short serial transfers between a host and a serial EEPROM over a clock line and one data line. The host writes the data register, then offers a control byte. The byte sets the number of clock pulses (0 to 8), the direction, whether the data line is released after the last rising clock, and whether completion waits for the EEPROM to pull the data line high. One accepted control byte gives one transfer of up to eight bits. Software raises and lowers chip select itself, outside this block.

The serial clock idles low. It is made from an enable that comes from a divider of the system clock: each half period lasts `DIV` system cycles, so `DIV` = 100 gives 500 kHz from a 100 MHz clock. Outgoing bits change after a falling clock edge. Incoming bits are sampled at the rising edge, which matches SPI modes 0 and 3. A mode pin chooses the input. The data can come back on the same pad the engine drives, or on a separate input pin. The output pair `dq_o`/`dq_oe` serves as either the shared pad or the dedicated output pin. The engine shows a busy level and gives a one-cycle pulse when busy ends.

The control channel is valid/ready. `cmd_ready` is high exactly when the engine is idle. A control byte is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. A byte offered while busy is not taken and leaves no trace. The source may hold `cmd_valid` until ready returns, or it may drop the byte. The data register is a plain write/read port. It accepts writes only while idle and is meant to be read while idle.

Top module: `eeprom_shift_engine`

## Requirements
- R1: The control byte is laid out as follows: bit 7 is wait-for-ready, bit 6 is ignored, bit 5 is release-line, bit 4 is read (1) or write (0), and bits 3:0 are the clock count. `busy` is high in the cycle after the byte is accepted.
- R2: An accepted command gives exactly `count` serial clock pulses, and a count from 9 to 15 gives 8 pulses. `sclk` is low whenever `busy` is low, and each clock level lasts `DIV` system cycles.
- R3: A read samples the selected input at each rising clock edge, MSB first. After the transfer, the last `count` bits sit right-justified in `dat_rdata`, with all higher bits zero. `dq_oe` is low while the read clocks run.
- R4: A write sends bits 7, 6, 5 and so on of the data register, MSB first. The first bit is on `dq_o` before the first rising edge, and `dq_o` changes only after a falling edge. Once the clocks end, `dq_o` rests at 0.
- R5: With a count of zero, no clock pulse is issued and `busy` is high for exactly one cycle. Afterwards `dq_oe` equals the inverse of the release-line bit.
- R6: When release-line is 1, `dq_oe` goes low in the cycle after the last rising clock edge, while `sclk` is still high. When release-line is 0, `dq_oe` is high once the command ends.
- R7: When wait-for-ready and release-line are both 1, `busy` stays high after the final falling edge until the selected input is seen going from 0 to 1. That rise ends busy two cycles later. With release-line at 0, wait-for-ready has no effect.
- R8: `done_irq` is high for exactly one cycle: the first cycle in which `busy` is low again. Without a wait, `busy` lasts 2·count·`DIV`+1 cycles.
- R9: With `split_pins` = 0, bits are taken from `dq_i`. With `split_pins` = 1, they are taken from `di_i`. The unselected input has no effect on the result.
- R10: `cmd_ready` is the inverse of `busy`. A control byte offered while busy starts nothing. A data register write while busy does not change the data register.
- R11: After reset the block is idle. `sclk`, `dq_oe` and `done_irq` are low, `cmd_ready` is high, and `dat_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| cmd_valid | input | 1 | Control byte offered |
| cmd_ready | output | 1 | Engine idle, control byte can be taken |
| cmd_ctl | input | 8 | Control byte (layout in R1) |
| dat_we | input | 1 | Data register write strobe (idle only) |
| dat_wdata | input | 8 | Data register write value |
| dat_rdata | output | 8 | Data register contents |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle pulse when busy ends |
| split_pins | input | 1 | 0: shared data pad, 1: separate input pin |
| sclk | output | 1 | Serial clock |
| dq_o | output | 1 | Serial data out value |
| dq_oe | output | 1 | Serial data out enable |
| dq_i | input | 1 | Shared pad readback |
| di_i | input | 1 | Separate serial data input |

## Verification
The assertions assume that every input is synchronous to `clk`, that `DIV` is at least 2, and that the data inputs change only while the serial clock is low. The bench meets these conditions by moving `dq_i` and `di_i` only right after it sees a falling `sclk`. It sets the first read bit before the command is offered. In the wait-for-ready case, it holds the input low until after the final falling edge, so the awaited rise is the only transition the engine can see. Control bytes are offered during busy on purpose, and only to show that they are refused.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned CNT_W = 4;

  typedef struct packed {
    logic             wait_rdy;
    logic             spare;
    logic             rel;
    logic             rd;
    logic [CNT_W-1:0] count;
  } ctl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_WAIT, ST_FIN} st_t;

  // Counts above the register width are treated as a full byte.
  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(DW)) ? CNT_W'(DW) : c;
  endfunction
endpackage

// File: rtl/eep_tick_gen.sv
module eep_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/eep_shifter.sv
module eep_shifter import eep_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [DW-1:0] host_d,
  input  logic          clr,
  input  logic          shl,
  input  logic          cap,
  input  logic          cap_bit,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (clr)     q <= '0;
    else if (cap)     q <= {q[DW-2:0], cap_bit};
    else if (shl)     q <= {q[DW-2:0], 1'b0};
    else if (host_we) q <= host_d;
  end
endmodule

// File: rtl/eep_seq.sv
module eep_seq import eep_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  ctl_t ctl,
  input  logic tick,
  input  logic din,
  output logic busy,
  output logic en,
  output logic sclk,
  output logic oe,
  output logic irq,
  output logic clr,
  output logic shl,
  output logic cap,
  output logic tx_on
);
  st_t              state;
  logic [CNT_W-1:0] left;
  logic             c_wait, c_rel, c_rd, din_q;
  logic [CNT_W-1:0] n_start;

  assign n_start = clamp_count(ctl.count);
  assign busy    = (state != ST_IDLE);
  assign en      = (state == ST_LOW) || (state == ST_HIGH);
  assign clr     = start && ctl.rd;
  assign cap     = tick && (state == ST_LOW) && c_rd;
  assign shl     = tick && (state == ST_HIGH) && !c_rd;
  assign tx_on   = en && !c_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      left   <= '0;
      c_wait <= 1'b0;
      c_rel  <= 1'b0;
      c_rd   <= 1'b0;
      sclk   <= 1'b0;
      oe     <= 1'b0;
      irq    <= 1'b0;
      din_q  <= 1'b0;
    end else begin
      irq   <= (state == ST_FIN);
      din_q <= din;
      unique case (state)
        ST_IDLE: if (start) begin
          c_wait <= ctl.wait_rdy;
          c_rel  <= ctl.rel;
          c_rd   <= ctl.rd;
          left   <= n_start;
          if (n_start == '0) begin
            oe    <= !ctl.rel;
            state <= (ctl.wait_rdy && ctl.rel) ? ST_WAIT : ST_FIN;
          end else begin
            oe    <= !ctl.rd;
            state <= ST_LOW;
          end
        end
        ST_LOW: if (tick) begin
          sclk  <= 1'b1;
          state <= ST_HIGH;
          if (left == CNT_W'(1)) oe <= !c_rel;
        end
        ST_HIGH: if (tick) begin
          sclk <= 1'b0;
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) state <= (c_wait && c_rel) ? ST_WAIT : ST_FIN;
          else                   state <= ST_LOW;
        end
        ST_WAIT: if (din && !din_q) state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_shift_engine.sv
module eeprom_shift_engine import eep_pkg::*; #(
  parameter int unsigned DIV = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_ctl,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic          busy,
  output logic          done_irq,
  input  logic          split_pins,
  output logic          sclk,
  output logic          dq_o,
  output logic          dq_oe,
  input  logic          dq_i,
  input  logic          di_i
);
  logic start, tick, en, clr, shl, cap, tx_on, din, host_we;
  logic spare_unused;
  ctl_t ctl;

  assign ctl          = ctl_t'(cmd_ctl);
  assign spare_unused = ctl.spare;
  assign cmd_ready    = !busy;
  assign start        = cmd_valid && !busy;
  assign host_we      = dat_we && !busy;
  assign din          = split_pins ? di_i : dq_i;
  assign dq_o         = tx_on & dat_rdata[DW-1];

  eep_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
  );

  eep_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .tick(tick), .din(din),
    .busy(busy), .en(en), .sclk(sclk), .oe(dq_oe), .irq(done_irq),
    .clr(clr), .shl(shl), .cap(cap), .tx_on(tx_on)
  );

  eep_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_d(dat_wdata),
    .clr(clr), .shl(shl), .cap(cap), .cap_bit(din), .q(dat_rdata)
  );
endmodule

// File: rtl/eep_engine_chk.sv
module eep_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_ctl,
  input logic       busy,
  input logic       done_irq,
  input logic       sclk,
  input logic       dq_o
);
  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(dq_o));

  // R8
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_ctl[3:0] == 4'd0) && !(cmd_ctl[7] && cmd_ctl[5])
      |=> busy ##1 !busy);
endmodule

bind eeprom_shift_engine eep_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_ctl(cmd_ctl), .busy(busy), .done_irq(done_irq), .sclk(sclk), .dq_o(dq_o)
);

// File: tb/sim_eeprom_shift_engine.sv
module sim_eeprom_shift_engine;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, dat_we = 0, split_pins = 0, dq_i = 0, di_i = 0;
  logic [7:0] cmd_ctl = 0, dat_wdata = 0;
  logic cmd_ready, busy, done_irq, sclk, dq_o, dq_oe;
  logic [7:0] dat_rdata;

  int total = 0, bad = 0;
  bit finished = 0, tx_watch = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  eeprom_shift_engine #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ctl(cmd_ctl), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .busy(busy), .done_irq(done_irq), .split_pins(split_pins), .sclk(sclk),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .di_i(di_i)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected serial bits at each rising sclk, watches the pulse.
  bit m_sq = 0, m_bq = 0, m_iq = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !m_sq && tx_watch) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected bit", dq_o, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(dq_o === e, "R4", "serial bit", dq_o, e);
        end
      end
      if (!busy && m_bq) chk(done_irq === 1'b1, "R8", "pulse at busy end", done_irq, 1);
      if (m_iq) chk(done_irq === 1'b0, "R8", "pulse one cycle", done_irq, 0);
    end
    m_sq = sclk; m_bq = busy; m_iq = done_irq;
  end

  task automatic issue(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_ctl = c;
    @(negedge clk); cmd_valid = 0;
    chk(busy === 1'b1, "R1", "busy after accept", busy, 1);
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic do_write(input logic [7:0] d, input int cnt, input bit rel, input bit wfr, input bit spare);
    int n, nb, nr;
    bit sq, seen;
    n = (cnt > 8) ? 8 : cnt;
    load(d);
    for (int i = 0; i < n; i++) exp_q.push_back(d[7-i]);
    tx_watch = 1;
    issue({wfr, spare, rel, 1'b0, 4'(cnt)});
    nb = 0; nr = 0; sq = 0; seen = 0;
    while (busy) begin
      nb++;
      if (sclk && !sq) nr++;
      if (rel && sclk && nr == n && !seen) begin
        seen = 1;
        chk(dq_oe === 1'b0, "R6", "released after last rise", dq_oe, 0);
      end
      sq = sclk;
      @(negedge clk);
    end
    tx_watch = 0;
    chk(exp_q.size() == 0, "R4", "all bits sent", exp_q.size(), 0);
    exp_q.delete();
    chk(nr == n, "R2", "pulse count", nr, n);
    chk(nb == 2*n*DIV+1, "R8", "busy length (R7 no wait when release=0)", nb, 2*n*DIV+1);
    chk(dq_oe === !rel, "R6", "drive after command", dq_oe, !rel);
    chk(dq_o === 1'b0, "R4", "rest value", dq_o, 0);
  endtask

  task automatic set_line(input bit b);
    if (split_pins) begin di_i = b; dq_i = ~b; end
    else begin dq_i = b; di_i = ~b; end
  endtask

  task automatic do_read(input logic [7:0] v, input int n, input bit rel, input bit split);
    int nb, nr;
    bit sq, seen, rej, pend;
    logic [7:0] ex;
    load(8'hFF);
    split_pins = split;
    set_line(v[n-1]);
    issue({1'b0, 1'b0, rel, 1'b1, 4'(n)});
    nb = 0; nr = 0; sq = 0; seen = 0; rej = 0; pend = 0;
    while (busy) begin
      if (pend) begin cmd_valid = 0; dat_we = 0; pend = 0; end
      nb++;
      if (sclk && !sq) nr++;
      if (!sclk && sq && nr < n) set_line(v[n-1-nr]);
      if (sclk && nr == 1 && !seen) begin
        seen = 1;
        chk(dq_oe === 1'b0, "R3", "line released while reading", dq_oe, 0);
      end
      if (nr == 1 && !rej) begin
        rej = 1; pend = 1;
        chk(cmd_ready === 1'b0, "R10", "not ready while busy", cmd_ready, 0);
        cmd_valid = 1; cmd_ctl = 8'h08; dat_we = 1; dat_wdata = 8'h00;
      end
      sq = sclk;
      @(negedge clk);
    end
    cmd_valid = 0; dat_we = 0;
    ex = v & 8'((1 << n) - 1);
    chk(dat_rdata === ex, split ? "R9" : "R3", "read value", dat_rdata, ex);
    chk(nr == n, "R2", "read pulse count", nr, n);
    chk(nb == 2*n*DIV+1, "R8", "read busy length", nb, 2*n*DIV+1);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", "refused command did not start", busy, 0);
    dq_i = 0; di_i = 0;
  endtask

  task automatic zero_cmd(input bit rel);
    issue({1'b0, 1'b0, rel, 1'b0, 4'd0});
    chk(sclk === 1'b0, "R5", "no clock", sclk, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R5", "one busy cycle", busy, 0);
    chk(sclk === 1'b0, "R5", "no clock after", sclk, 0);
    chk(dq_oe === !rel, "R5", "line follows release bit", dq_oe, !rel);
  endtask

  task automatic wait_test();
    int nr;
    bit sq;
    split_pins = 0; dq_i = 0;
    load(8'h5A);
    issue({1'b1, 1'b0, 1'b1, 1'b0, 4'd4});
    nr = 0; sq = 0;
    while (!(nr == 4 && !sclk)) begin
      if (sclk && !sq) nr++;
      sq = sclk;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(busy === 1'b1, "R7", "held for ready", busy, 1);
    dq_i = 1;
    @(negedge clk);
    chk(busy === 1'b1, "R7", "finishing", busy, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R7", "ends after rise", busy, 0);
    dq_i = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(busy === 1'b0, "R11", "reset busy", busy, 0);
    chk(sclk === 1'b0, "R11", "reset sclk", sclk, 0);
    chk(dq_oe === 1'b0, "R11", "reset oe", dq_oe, 0);
    chk(done_irq === 1'b0, "R11", "reset irq", done_irq, 0);
    chk(cmd_ready === 1'b1, "R11", "reset ready", cmd_ready, 1);
    chk(dat_rdata === 8'h00, "R11", "reset data", dat_rdata, 0);

    do_write(8'hA5, 8, 0, 0, 0);
    do_write(8'hB0, 3, 1, 0, 1);   // R1 spare bit set, R6 release
    do_write(8'h3C, 12, 0, 1, 0);  // R2 clamp, R7 no effect
    do_read(8'h3C, 8, 1, 0);
    do_read(8'h16, 5, 1, 0);       // R3 right-justified
    do_read(8'h2D, 6, 0, 1);       // R9 separate input
    zero_cmd(1);
    zero_cmd(0);
    wait_test();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule